// File: doc/BRIEF.md
# Clock Generator Control Register Target

This block is the two-wire serial control port of a clock generator. It runs as a target on an SMBus/I2C bus and holds a small register file. The file sets the output frequency code, the spread-spectrum on/off and style, the enable of each of eight outputs, whether each output honours the global stop request, and whether a stopped output is parked driven or released. It samples both bus lines on the system clock. It never drives the data line high, and it never stretches the clock.

A host writes with the write address 0xDC, a start index, a byte count and then that many data bytes. A host reads by writing the index and then issuing a repeated START with the read address 0xDD. The target then returns a byte count followed by register contents, and the index advances after every byte. The frequency code and spread style come from strap pins captured during reset. Software can replace them only after it has set a control bit that hands those fields over to it.

Top module: `clkgen_ctrl_target`

## Requirements
- R1: While reset is low, the strap pins are captured. After reset the outputs are freqSel = straps, spreadOn = strap, spreadCenter = strap, stopHiZ = 0, outEnable = 0xFF, stopMode = 0x80, sdaOe = 0, and the read count is 7.
- R2: A write transaction is START, 0xDC, index N, count X, then data. The target acknowledges every byte and stores data byte k in register N+k. Register 1 drives outEnable and register 2 drives stopMode.
- R3: Data bytes beyond the count X are still acknowledged but are discarded.
- R4: Register 0 has the layout bits 7:4 frequency code, bit 3 spread on, bit 2 software ownership, bit 1 stop drive (1 = released), bit 0 spread style (1 = centre). Bits 3..1 always take written data. Bits 7:4 and bit 0 take written data only if bit 2 was already 1 before that write.
- R5: A read transaction is START, 0xDC, N, repeated START, 0xDD. It returns register 6 (the count, writable) first and then registers N, N+1, and so on. Transmission continues while the host acknowledges and stops at the host's NACK.
- R6: Register 3 reads {captured code[3:0], captured spread, 0, 0, captured style} regardless of later strap or software changes. Register 4 reads 0x01, register 5 reads 0x07, and indices above 6 read 0x00.
- R7: Writes to indices 3, 4, 5 and above 6 are acknowledged and have no effect.
- R8: An address byte other than 0xDC or 0xDD is not acknowledged, and the rest of that transaction changes nothing.
- R9: A STOP at any point, including in the middle of a byte, returns the target to idle with no partial write. The next transaction then works normally.
- R10: The target only ever pulls SDA low (sdaOut is 0), and sdaOe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Synchronous active-low reset; straps captured while low |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOut | output | 1 | Data pad output value, always 0 |
| sdaOe | output | 1 | Data pad output enable (1 pulls SDA low) |
| strapFs | input | 4 | Frequency code strap pins |
| strapSpread | input | 1 | Spread on/off strap pin |
| strapCenter | input | 1 | Spread style strap pin (1 = centre) |
| freqSel | output | 4 | Active frequency code |
| spreadOn | output | 1 | Spread modulation enabled |
| spreadCenter | output | 1 | Spread style: 0 down, 1 centre |
| stopHiZ | output | 1 | Stopped outputs released (1) or parked driven (0) |
| outEnable | output | 8 | Per-output enables |
| stopMode | output | 8 | Per-output stop-able (1) or free-running (0) |

## Verification
The bench aims at the ownership interlock of register 0. A single write that both claims ownership and changes the frequency code must leave the code untouched, and a design that tests the newly written bit would let the code through one write early. It also drives counts shorter than the data stream, writes into read-only and unmapped slots, and reads past the last register. Each of these shows up as stray output changes or as nonzero bytes where zeros are due. A mid-byte STOP and a foreign address are also sent. A design that does not resynchronize on them either commits a partial byte or answers the next read one bit out of step.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [DATA_W-1:0] wrIdx;
    logic [DATA_W-1:0] wrData;
    logic [DATA_W-1:0] rdIdx;
  } regCmd_t;

  typedef enum logic [1:0] {BUS_IDLE, BUS_RX, BUS_TX, BUS_WAIT} busMode_e;
  typedef enum logic [2:0] {PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA, PH_TURN} rxPhase_e;

  localparam logic [DATA_W-1:0] IDX_CTRL   = 8'd0;
  localparam logic [DATA_W-1:0] IDX_OE     = 8'd1;
  localparam logic [DATA_W-1:0] IDX_STOP   = 8'd2;
  localparam logic [DATA_W-1:0] IDX_STRAP  = 8'd3;
  localparam logic [DATA_W-1:0] IDX_VENDOR = 8'd4;
  localparam logic [DATA_W-1:0] IDX_DEVICE = 8'd5;
  localparam logic [DATA_W-1:0] IDX_COUNT  = 8'd6;
endpackage

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
  import clkctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] VENDOR_REV  = 8'h01,
  parameter logic [DATA_W-1:0] DEVICE_ID   = 8'h07,
  parameter logic [DATA_W-1:0] OE_RESET    = 8'hFF,
  parameter logic [DATA_W-1:0] STOP_RESET  = 8'h80,
  parameter logic [DATA_W-1:0] COUNT_RESET = 8'd7
) (
  input  logic              clk,
  input  logic              rstN,
  input  regCmd_t           cmd,
  input  logic [3:0]        strapFs,
  input  logic              strapSpread,
  input  logic              strapCenter,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cntByte,
  output logic [3:0]        freqSel,
  output logic              spreadOn,
  output logic              spreadCenter,
  output logic              stopHiZ,
  output logic [DATA_W-1:0] outEnable,
  output logic [DATA_W-1:0] stopMode
);
  logic [3:0] capFs;
  logic       capSpread, capCenter;
  logic       swOwn;
  logic [DATA_W-1:0] strapView;

  // Straps are captured for as long as reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capFs     <= strapFs;
      capSpread <= strapSpread;
      capCenter <= strapCenter;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqSel      <= strapFs;
      spreadOn     <= strapSpread;
      spreadCenter <= strapCenter;
      swOwn        <= 1'b0;
      stopHiZ      <= 1'b0;
      outEnable    <= OE_RESET;
      stopMode     <= STOP_RESET;
      cntByte      <= COUNT_RESET;
    end else if (cmd.wrEn) begin
      unique case (cmd.wrIdx)
        IDX_CTRL: begin
          spreadOn <= cmd.wrData[3];
          swOwn    <= cmd.wrData[2];
          stopHiZ  <= cmd.wrData[1];
          if (swOwn) begin
            freqSel      <= cmd.wrData[7:4];
            spreadCenter <= cmd.wrData[0];
          end
        end
        IDX_OE:    outEnable <= cmd.wrData;
        IDX_STOP:  stopMode  <= cmd.wrData;
        IDX_COUNT: cntByte   <= cmd.wrData;
        default: ;
      endcase
    end
  end

  assign strapView = {capFs, capSpread, 2'b00, capCenter};

  always_comb begin
    unique case (cmd.rdIdx)
      IDX_CTRL:   rdData = {freqSel, spreadOn, swOwn, stopHiZ, spreadCenter};
      IDX_OE:     rdData = outEnable;
      IDX_STOP:   rdData = stopMode;
      IDX_STRAP:  rdData = strapView;
      IDX_VENDOR: rdData = VENDOR_REV;
      IDX_DEVICE: rdData = DEVICE_ID;
      IDX_COUNT:  rdData = cntByte;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/ctl_bus_fsm.sv
module ctl_bus_fsm
  import clkctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] WR_ADDR     = 8'hDC,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] cntByte,
  output regCmd_t           cmd,
  output logic              sdaOe
);
  localparam logic [DATA_W-1:0] RD_ADDR = WR_ADDR | 8'h01;
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = !sclPrev && sclS;
  assign sclFall  = sclPrev && !sclS;
  assign startDet = sclPrev && sclS && sdaPrev && !sdaS;
  assign stopDet  = sclPrev && sclS && !sdaPrev && sdaS;

  busMode_e mode;
  rxPhase_e phase;
  logic [3:0]        bitCnt;
  logic [DATA_W-1:0] shiftIn, txByte, idxReg, remain;
  logic [DATA_W-1:0] wrIdxR, wrDataR;
  logic              wrEnR, sdaOeR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= BUS_IDLE;
      phase   <= PH_ADDR;
      bitCnt  <= '0;
      shiftIn <= '0;
      txByte  <= '0;
      idxReg  <= '0;
      remain  <= '0;
      wrEnR   <= 1'b0;
      wrIdxR  <= '0;
      wrDataR <= '0;
      sdaOeR  <= 1'b0;
    end else begin
      wrEnR <= 1'b0;
      if (stopDet) begin
        mode   <= BUS_IDLE;
        sdaOeR <= 1'b0;
      end else if (startDet) begin
        mode   <= BUS_RX;
        phase  <= PH_ADDR;
        bitCnt <= '0;
        sdaOeR <= 1'b0;
      end else begin
        unique case (mode)
          BUS_RX: begin
            if (sclRise && bitCnt < LAST_BIT) begin
              shiftIn <= {shiftIn[DATA_W-2:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == LAST_BIT) begin
              bitCnt <= ACK_SLOT;
              sdaOeR <= 1'b1;
              unique case (phase)
                PH_ADDR: begin
                  if (shiftIn == WR_ADDR) phase <= PH_INDEX;
                  else if (shiftIn == RD_ADDR) phase <= PH_TURN;
                  else begin
                    mode   <= BUS_WAIT;
                    sdaOeR <= 1'b0;
                  end
                end
                PH_INDEX: begin
                  idxReg <= shiftIn;
                  phase  <= PH_COUNT;
                end
                PH_COUNT: begin
                  remain <= shiftIn;
                  phase  <= PH_DATA;
                end
                PH_DATA: begin
                  wrEnR   <= (remain != '0);
                  wrIdxR  <= idxReg;
                  wrDataR <= shiftIn;
                  idxReg  <= idxReg + 8'd1;
                  if (remain != '0) remain <= remain - 8'd1;
                end
                default: ;
              endcase
            end else if (sclFall && bitCnt == ACK_SLOT) begin
              bitCnt <= '0;
              if (phase == PH_TURN) begin
                mode   <= BUS_TX;
                txByte <= cntByte;
                sdaOeR <= !cntByte[DATA_W-1];
              end else begin
                sdaOeR <= 1'b0;
              end
            end
          end
          BUS_TX: begin
            if (sclRise && bitCnt < LAST_BIT) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclRise && bitCnt == LAST_BIT) begin
              if (sdaS) mode <= BUS_WAIT;
              else bitCnt <= ACK_SLOT;
            end else if (sclFall && bitCnt == LAST_BIT) begin
              sdaOeR <= 1'b0;
            end else if (sclFall && bitCnt == ACK_SLOT) begin
              txByte <= rdData;
              sdaOeR <= !rdData[DATA_W-1];
              idxReg <= idxReg + 8'd1;
              bitCnt <= '0;
            end else if (sclFall && bitCnt != '0) begin
              sdaOeR <= !txByte[DATA_W-2];
              txByte <= {txByte[DATA_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd.wrEn   = wrEnR;
  assign cmd.wrIdx  = wrIdxR;
  assign cmd.wrData = wrDataR;
  assign cmd.rdIdx  = idxReg;
  assign sdaOe      = sdaOeR;
endmodule

// File: rtl/clkgen_ctrl_target.sv
module clkgen_ctrl_target
  import clkctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] WR_ADDR     = 8'hDC,
  parameter int                SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOut,
  output logic       sdaOe,
  input  logic [3:0] strapFs,
  input  logic       strapSpread,
  input  logic       strapCenter,
  output logic [3:0] freqSel,
  output logic       spreadOn,
  output logic       spreadCenter,
  output logic       stopHiZ,
  output logic [7:0] outEnable,
  output logic [7:0] stopMode
);
  regCmd_t           regCmd;
  logic [DATA_W-1:0] rdData, cntByte;

  ctl_bus_fsm #(.WR_ADDR(WR_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .cntByte(cntByte), .cmd(regCmd), .sdaOe(sdaOe)
  );

  ctl_reg_file u_regs (
    .clk(clk), .rstN(rstN), .cmd(regCmd),
    .strapFs(strapFs), .strapSpread(strapSpread), .strapCenter(strapCenter),
    .rdData(rdData), .cntByte(cntByte),
    .freqSel(freqSel), .spreadOn(spreadOn), .spreadCenter(spreadCenter),
    .stopHiZ(stopHiZ), .outEnable(outEnable), .stopMode(stopMode)
  );

  assign sdaOut = 1'b0;
endmodule

// File: rtl/clkgen_ctrl_checker.sv
module clkgen_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic [3:0] freqSel,
  input logic [7:0] outEnable,
  input logic [7:0] stopMode,
  input logic       wrEn,
  input logic [7:0] wrIdx
);
  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (outEnable == 8'hFF && stopMode == 8'h80)); // R1
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn); // R2
  AST_STOPMODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stopMode) |-> $past(wrEn && wrIdx == 8'd2)); // R2
  AST_OE_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outEnable) |-> $past(wrEn && wrIdx == 8'd1)); // R7
  AST_FS_BY_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqSel) |-> $past(wrEn && wrIdx == 8'd0)); // R4
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R10
endmodule

bind clkgen_ctrl_target clkgen_ctrl_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .freqSel(freqSel),
  .outEnable(outEnable), .stopMode(stopMode),
  .wrEn(regCmd.wrEn), .wrIdx(regCmd.wrIdx)
);

// File: tb/tb_clkgen_ctrl_target.sv
module tb_clkgen_ctrl_target;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, scl = 1'b1, hostSda = 1'b1;
  logic [3:0] strapFs = 4'hA;
  logic strapSpread = 1'b1, strapCenter = 1'b0;
  logic sdaOut, sdaOe, spreadOn, spreadCenter, stopHiZ;
  logic [3:0] freqSel;
  logic [7:0] outEnable, stopMode;
  wire  sdaLine = hostSda & ~sdaOe;

  clkgen_ctrl_target dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOut(sdaOut), .sdaOe(sdaOe),
    .strapFs(strapFs), .strapSpread(strapSpread), .strapCenter(strapCenter),
    .freqSel(freqSel), .spreadOn(spreadOn), .spreadCenter(spreadCenter), .stopHiZ(stopHiZ),
    .outEnable(outEnable), .stopMode(stopMode)
  );

  localparam int HP = 10;
  localparam int Q  = 5;
  int checks = 0, errors = 0;
  bit cmpEn = 1'b0, doneFlag = 1'b0, prevOe = 1'b0;
  logic [7:0] mdl [0:6];
  logic [7:0] txQ [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] expRead(input int i);
    if (i > 6) return 8'h00;
    return mdl[i];
  endfunction

  task automatic modelWrite(input int i, input logic [7:0] d);
    logic [7:0] o;
    o = mdl[0];
    case (i)
      0: mdl[0] = {o[2] ? d[7:4] : o[7:4], d[3], d[2], d[1], o[2] ? d[0] : o[0]};
      1, 2, 6: mdl[i] = d;
      default: ;
    endcase
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    tick(Q); hostSda = 1'b1; tick(HP); scl = 1'b1; tick(HP); hostSda = 1'b0; tick(HP); scl = 1'b0;
  endtask

  task automatic busStop();
    tick(Q); hostSda = 1'b0; tick(HP); scl = 1'b1; tick(HP); hostSda = 1'b1; tick(HP);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); hostSda = b[i]; tick(HP); scl = 1'b1; tick(HP); scl = 1'b0;
    end
    tick(Q); hostSda = 1'b1; tick(HP); scl = 1'b1; tick(HP/2); ack = sdaLine; tick(HP/2); scl = 1'b0;
  endtask

  task automatic recvByte(input bit hostAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); tick(HP); scl = 1'b1; tick(HP/2); b[i] = sdaLine; tick(HP/2); scl = 1'b0;
    end
    tick(Q); hostSda = hostAck ? 1'b0 : 1'b1; tick(HP); scl = 1'b1; tick(HP); scl = 1'b0;
    tick(Q); hostSda = 1'b1;
  endtask

  // data bytes come from txQ; only the first cnt update the model
  task automatic writeBlock(input int idx, input int cnt, input string req);
    logic ack;
    cmpEn = 1'b0;
    busStart();
    sendByte(8'hDC, ack);       chk(ack == 1'b0, {req, " addr ack"}, ack, 0);
    sendByte(8'(idx), ack);     chk(ack == 1'b0, {req, " index ack"}, ack, 0);
    sendByte(8'(cnt), ack);     chk(ack == 1'b0, {req, " count ack"}, ack, 0);
    for (int k = 0; k < txQ.size(); k++) begin
      sendByte(txQ[k], ack);    chk(ack == 1'b0, {req, " data ack"}, ack, 0);
      if (k < cnt) modelWrite(idx + k, txQ[k]);
    end
    busStop();
    cmpEn = 1'b1;
  endtask

  task automatic readBlock(input int idx, input int n, input string req);
    logic ack;
    logic [7:0] b;
    cmpEn = 1'b0;
    busStart();
    sendByte(8'hDC, ack);   chk(ack == 1'b0, {req, " wr addr ack"}, ack, 0);
    sendByte(8'(idx), ack); chk(ack == 1'b0, {req, " index ack"}, ack, 0);
    busStart();
    sendByte(8'hDD, ack);   chk(ack == 1'b0, {req, " rd addr ack"}, ack, 0);
    recvByte(n > 0, b);     chk(b == mdl[6], {req, " count byte"}, b, mdl[6]);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      chk(b == expRead(idx + k), {req, " read data"}, b, expRead(idx + k));
    end
    busStop();
    cmpEn = 1'b1;
  endtask

  // reference comparison of decoded outputs on every clock while the bus is quiet (R2, R4)
  always @(negedge clk) begin
    if (cmpEn && rstN && !doneFlag) begin
      chk({freqSel, spreadOn, stopHiZ, spreadCenter, outEnable, stopMode} ==
          {mdl[0][7:4], mdl[0][3], mdl[0][1], mdl[0][0], mdl[1], mdl[2]}, "R2/R4 outputs vs model",
          {freqSel, spreadOn, stopHiZ, spreadCenter, outEnable, stopMode},
          {mdl[0][7:4], mdl[0][3], mdl[0][1], mdl[0][0], mdl[1], mdl[2]});
    end
  end

  // R10: data line driven only low, and only moved while SCL is low
  always @(negedge clk) begin
    if (rstN && !doneFlag && sdaOe != prevOe) begin
      chk(!scl && sdaOut == 1'b0, "R10 sda change under scl low", scl, 0);
    end
    prevOe = sdaOe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic ack;
    mdl[0] = {4'hA, 1'b1, 1'b0, 1'b0, 1'b0};
    mdl[1] = 8'hFF; mdl[2] = 8'h80; mdl[3] = {4'hA, 1'b1, 2'b00, 1'b0};
    mdl[4] = 8'h01; mdl[5] = 8'h07; mdl[6] = 8'h07;
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chk(freqSel == 4'hA && spreadOn && !spreadCenter && !stopHiZ, "R1 strap fields", {freqSel, spreadOn, spreadCenter, stopHiZ}, 16'hA10);
    chk(outEnable == 8'hFF && stopMode == 8'h80, "R1 enables/stop", {outEnable, stopMode}, 16'hFF80);
    chk(sdaOe == 1'b0, "R1 sda released", sdaOe, 0);
    // straps move after reset; captured values must stay (R6)
    strapFs = 4'h5; strapSpread = 1'b0; strapCenter = 1'b1;
    cmpEn = 1'b1;
    tick(4);
    readBlock(0, 7, "R5 default read");
    txQ = {8'h5A, 8'h3C};
    writeBlock(1, 2, "R2 block write");
    chk(outEnable == 8'h5A && stopMode == 8'h3C, "R2 outputs", {outEnable, stopMode}, 16'h5A3C);
    // R4: claiming ownership and changing code in one write leaves code alone
    txQ = {8'hF5};
    writeBlock(0, 1, "R4 claim");
    chk(freqSel == 4'hA && !spreadCenter && !spreadOn, "R4 code locked on claim", {freqSel, spreadCenter}, 8'hA0);
    txQ = {8'h34};
    writeBlock(0, 1, "R4 owned");
    chk(freqSel == 4'h3 && !spreadCenter, "R4 code taken", freqSel, 3);
    txQ = {8'h3F};
    writeBlock(0, 1, "R4 fields");
    chk(spreadOn && stopHiZ && spreadCenter, "R4 spread/hiz/center", {spreadOn, stopHiZ, spreadCenter}, 7);
    readBlock(3, 4, "R6 strap and id readback");
    txQ = {8'h03};
    writeBlock(6, 1, "R5 count write");
    readBlock(4, 3, "R5 short count");
    readBlock(5, 3, "R6 past end");
    txQ = {8'hAA, 8'hBB, 8'hCC, 8'h07, 8'hEE};
    writeBlock(3, 5, "R7 read-only write");
    readBlock(3, 4, "R7 unchanged");
    txQ = {8'h11, 8'h22};
    writeBlock(1, 1, "R3 extra byte");
    chk(outEnable == 8'h11 && stopMode == 8'h3C, "R3 extra discarded", {outEnable, stopMode}, 16'h113C);
    // R8 foreign address
    cmpEn = 1'b0;
    busStart();
    sendByte(8'hA0, ack); chk(ack == 1'b1, "R8 no ack", ack, 1);
    sendByte(8'h02, ack); sendByte(8'h01, ack); sendByte(8'h00, ack);
    busStop();
    cmpEn = 1'b1;
    tick(3);
    chk(stopMode == 8'h3C, "R8 no effect", stopMode, 8'h3C);
    // R9 STOP in the middle of a data byte
    cmpEn = 1'b0;
    busStart();
    sendByte(8'hDC, ack); sendByte(8'h02, ack); sendByte(8'h01, ack);
    for (int i = 0; i < 4; i++) begin
      tick(Q); hostSda = 1'b0; tick(HP); scl = 1'b1; tick(HP); scl = 1'b0;
    end
    busStop();
    cmpEn = 1'b1;
    tick(3);
    chk(stopMode == 8'h3C, "R9 no partial write", stopMode, 8'h3C);
    readBlock(0, 7, "R9 recovery read");
    tick(10);
    finishRun();
  end
endmodule